// File: doc/BRIEF.md
# Front-Side Bus Memory Target

This block answers transactions on a split-phase processor front-side bus. A requester pulls the active-low address strobe low for one clock while presenting a quadword address and a 5-bit request code on the shared address pins. In the next clock the same pins carry the byte-lane enables and configuration bits. The target decodes the request and runs a data phase against a small internal store. The store holds a memory space and a separate I/O space.

The model has one packet per `clk` cycle, so four consecutive cycles make up one bus clock of the quad-pumped data bus. A cacheable burst moves a whole 64-byte line as eight quadwords over two bus clocks. The requester gives only the starting quadword and the target produces the rest. A non-cacheable memory or I/O request moves one quadword, qualified by its byte enables. Data-ready is held low for every packet. The 3-bit response appears on the final packet and ends the transaction. Only one transaction is outstanding at a time.

Top module: `fsb_target`

## Requirements
- R1: After reset, `drdy_n` is 1, `rs` is 3'b000 (idle) and `d_out` is zero.
- R2: The clock edge where `ads_n` is 0 captures the quadword address from `ab` and the code from `req`. The following edge captures the sub-phase-2 word from `ab`. The data phase starts in the cycle after that, with `drdy_n` at 0 in every packet cycle and at 1 otherwise.
- R3: Request codes are: 5'b00000 memory read burst, 5'b00001 memory write burst, 5'b00010 memory read partial, 5'b00011 memory write partial, 5'b00100 I/O read, 5'b00101 I/O write.
- R4: A burst runs eight consecutive packet cycles, which is two groups of four (two bus clocks). Each packet moves all 8 bytes.
- R5: Burst packet k uses quadword address {line, (start + k) mod 8}. Here start is `ab[2:0]` and line is the higher quadword bits of the first sub-phase, so the order wraps within the 64-byte line.
- R6: On a partial or I/O write, bit i of `ab[7:0]` in sub-phase 2 enables byte i (`d_in[8i+7:8i]`). Only enabled bytes of the stored quadword change.
- R7: A partial or I/O read is a single packet, and byte lanes whose enable is 0 read as zero.
- R8: I/O requests use storage separate from memory, so an I/O write never alters the memory quadword at the same address.
- R9: Any other request code gives one data-ready cycle with `rs` = 3'b011 (fail) and `d_out` zero, and it stores nothing.
- R10: `rs` is 3'b001 (complete) on the final data-ready cycle of a valid request and 3'b000 in all other cycles. Code 3'b010 (defer) is never driven.
- R11: An address strobe that arrives before the current transaction's final data-ready cycle is ignored.
- R12: A partial write with all enables 0 completes normally with one data-ready cycle and changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Packet-rate clock (four cycles per bus clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| ads_n | input | 1 | Active-low address strobe |
| ab | input | QAW (33) | Shared address pins: quadword address, then {config, byte enables} |
| req | input | 5 | Request code, valid with the strobe |
| d_in | input | 64 | Write data packet from the requester |
| d_out | output | 64 | Read data packet to the requester |
| drdy_n | output | 1 | Active-low data-ready, one cycle per packet |
| rs | output | 3 | Response code |

## Verification
The bench starts bursts at the first and at a late quadword of a line. A target that did not wrap would read past the line into the next one. Byte-masked writes and reads, including an all-zero mask, catch lane merging that writes whole quadwords or lets disabled lanes through to the read data. An I/O write aliased onto a memory address, and undefined codes that carry write data, would show as corrupted memory on read-back. A strobe injected in the middle of a burst would show as a second, unwanted data phase.

// File: rtl/fsb_tgt_pkg.sv
package fsb_tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUB2 = 2'd1,
        ST_DATA = 2'd2
    } tgt_state_e;

    localparam logic [4:0] REQ_MRD_LINE = 5'b00000;
    localparam logic [4:0] REQ_MWR_LINE = 5'b00001;
    localparam logic [4:0] REQ_MRD_PART = 5'b00010;
    localparam logic [4:0] REQ_MWR_PART = 5'b00011;
    localparam logic [4:0] REQ_IORD     = 5'b00100;
    localparam logic [4:0] REQ_IOWR     = 5'b00101;

    localparam logic [2:0] RS_IDLE = 3'b000;
    localparam logic [2:0] RS_DONE = 3'b001;
    localparam logic [2:0] RS_FAIL = 3'b011;

    localparam int QW_BYTES  = 8;
    localparam int LINE_QW   = 8;
    localparam int OFFW      = $clog2(LINE_QW);

endpackage

// File: rtl/fsb_req_decode.sv
module fsb_req_decode
    import fsb_tgt_pkg::*;
(
    input  logic [4:0] req,
    output logic       valid,
    output logic       burst,
    output logic       write,
    output logic       io
);
    always_comb begin
        valid = 1'b1;
        burst = 1'b0;
        write = 1'b0;
        io    = 1'b0;
        unique case (req)
            REQ_MRD_LINE: burst = 1'b1;
            REQ_MWR_LINE: begin burst = 1'b1; write = 1'b1; end
            REQ_MRD_PART: ;
            REQ_MWR_PART: write = 1'b1;
            REQ_IORD:     io = 1'b1;
            REQ_IOWR:     begin io = 1'b1; write = 1'b1; end
            default:      valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsb_qw_store.sv
module fsb_qw_store #(
    parameter int DEPTH = 64,
    parameter int LANES = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int DW   = LANES * 8
) (
    input  logic            clk,
    input  logic            we,
    input  logic [LANES-1:0] lane_en,
    input  logic [IDXW-1:0] idx,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] bitmask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bitmask[g*8 +: 8] = {8{lane_en[g]}};
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= (mem_q[idx] & ~bitmask) | (wdata & bitmask);
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/fsb_target.sv
module fsb_target
    import fsb_tgt_pkg::*;
#(
    parameter int QAW       = 33,
    parameter int DEPTH_QW  = 32,
    localparam int IDXW     = $clog2(DEPTH_QW),
    localparam int SIDXW    = IDXW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ads_n,
    input  logic [QAW-1:0] ab,
    input  logic [4:0]     req,
    input  logic [63:0]    d_in,
    output logic [63:0]    d_out,
    output logic           drdy_n,
    output logic [2:0]     rs
);
    typedef struct packed {
        tgt_state_e      st;
        logic [IDXW-1:0] qidx;
        logic            valid;
        logic            burst;
        logic            write;
        logic            io;
        logic [QW_BYTES-1:0] be;
        logic [OFFW-1:0] cnt;
    } tgt_regs_t;

    tgt_regs_t q, d;

    logic dec_valid, dec_burst, dec_write, dec_io;

    fsb_req_decode u_dec (
        .req   (req),
        .valid (dec_valid),
        .burst (dec_burst),
        .write (dec_write),
        .io    (dec_io)
    );

    logic                in_data, last_pkt, store_we;
    logic [OFFW-1:0]     cur_off;
    logic [SIDXW-1:0]    store_idx;
    logic [QW_BYTES-1:0] lane_en;
    logic [63:0]         rd_word, rd_mask;

    assign in_data   = (q.st == ST_DATA);
    assign last_pkt  = !q.burst || (q.cnt == OFFW'(LINE_QW - 1));
    assign cur_off   = q.qidx[OFFW-1:0] + q.cnt;
    assign store_idx = {q.io, q.qidx[IDXW-1:OFFW], cur_off};
    assign lane_en   = q.burst ? {QW_BYTES{1'b1}} : q.be;
    assign store_we  = in_data && q.valid && q.write;

    fsb_qw_store #(.DEPTH(2 * DEPTH_QW), .LANES(QW_BYTES)) u_store (
        .clk     (clk),
        .we      (store_we),
        .lane_en (lane_en),
        .idx     (store_idx),
        .wdata   (d_in),
        .rdata   (rd_word)
    );

    for (genvar g = 0; g < QW_BYTES; g++) begin : g_rmask
        assign rd_mask[g*8 +: 8] = {8{lane_en[g]}};
    end

    assign drdy_n = !in_data;
    assign rs     = (in_data && last_pkt) ? (q.valid ? RS_DONE : RS_FAIL) : RS_IDLE;
    assign d_out  = (in_data && q.valid && !q.write) ? (rd_word & rd_mask) : 64'd0;

    logic unused_pins;
    assign unused_pins = ^{ab[QAW-1:IDXW]};

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (!ads_n) begin
                    d.st    = ST_SUB2;
                    d.qidx  = ab[IDXW-1:0];
                    d.valid = dec_valid;
                    d.burst = dec_burst && dec_valid;
                    d.write = dec_write;
                    d.io    = dec_io;
                end
            end
            ST_SUB2: begin
                d.be  = ab[QW_BYTES-1:0];
                d.cnt = '0;
                d.st  = ST_DATA;
            end
            ST_DATA: begin
                if (last_pkt) d.st  = ST_IDLE;
                else          d.cnt = q.cnt + 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && q.burst && q.cnt != OFFW'(LINE_QW - 1)) |=> (in_data && q.cnt == $past(q.cnt) + 1'b1)) // R4
        else $error("burst did not advance");
    AST_SINGLE_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !q.burst) |=> (q.st == ST_IDLE)) // R7
        else $error("single transfer overran");
    AST_RESP_WITH_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
        (rs != RS_IDLE) |-> !drdy_n) // R10
        else $error("response without data-ready");
    AST_FAIL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !q.valid) |-> (rs == RS_FAIL && d_out == 64'd0 && !store_we)) // R9
        else $error("bad code moved data");
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.qidx)) // R11
        else $error("request captured while busy");
endmodule

// File: tb/fsb_target_tb.sv
module fsb_target_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ads_n = 1'b1;
    logic [32:0] ab = '0;
    logic [4:0]  req = '0;
    logic [63:0] d_in = '0;
    logic [63:0] d_out;
    logic        drdy_n;
    logic [2:0]  rs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] exp_mem [64];
    logic [63:0] wbuf [8];
    logic [63:0] rbuf [8];

    always #5 clk = ~clk;

    fsb_target u_dut (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .ab(ab), .req(req),
        .d_in(d_in), .d_out(d_out), .drdy_n(drdy_n), .rs(rs)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] bmask(input logic [7:0] be);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic int sidx(input bit io, input int line, input int off);
        return (io ? 32 : 0) + line * 8 + (off % 8);
    endfunction

    // one transaction: strobe, sub-phase 2, then npk packet cycles
    task automatic run(input int line, input int off, input logic [4:0] code, input logic [7:0] be,
                       input int npk, input logic [2:0] exp_rs, input int inject, input string tag);
        @(negedge clk);
        ads_n = 1'b0; ab = 33'(line * 8 + off); req = code;
        @(negedge clk);
        ads_n = 1'b1; ab = {25'd0, be}; req = 5'b11111;
        for (int k = 0; k < npk; k++) begin
            @(negedge clk);
            ads_n = 1'b1;
            d_in = wbuf[k];
            if (k == inject) begin
                ads_n = 1'b0; ab = 33'(8); req = 5'b00001;
            end
            chk(drdy_n == 1'b0, {tag, " R2 drdy in packet"}, 64'(drdy_n), 64'd0);
            chk(rs == ((k == npk - 1) ? exp_rs : 3'b000), {tag, " R10 response"}, 64'(rs),
                64'((k == npk - 1) ? exp_rs : 3'b000));
            rbuf[k] = d_out;
        end
        @(negedge clk);
        ads_n = 1'b1;
        chk(drdy_n == 1'b1 && rs == 3'b000, {tag, " R2 end of data phase"}, 64'({drdy_n, rs}), 64'h8);
    endtask

    task automatic t_reset;
        chk(drdy_n == 1'b1, "R1 drdy_n", 64'(drdy_n), 64'd1);
        chk(rs == 3'b000, "R1 rs", 64'(rs), 64'd0);
        chk(d_out == 64'd0, "R1 d_out", d_out, 64'd0);
    endtask

    task automatic t_burst_write(input int line, input int off, input int seed);
        for (int k = 0; k < 8; k++) wbuf[k] = {32'(seed + k), 32'hFACE0000 + 32'(k * 3)};
        run(line, off, 5'b00001, 8'h00, 8, 3'b001, -1, "R4 burst write");
        for (int k = 0; k < 8; k++) exp_mem[sidx(0, line, off + k)] = wbuf[k];
    endtask

    task automatic t_burst_read(input int line, input int off, input int inject, input string tag);
        run(line, off, 5'b00000, 8'h00, 8, 3'b001, inject, tag);
        for (int k = 0; k < 8; k++)
            chk(rbuf[k] === exp_mem[sidx(0, line, off + k)], {tag, " R5 packet order"},
                rbuf[k], exp_mem[sidx(0, line, off + k)]);
    endtask

    task automatic t_part_read(input bit io, input int line, input int off, input logic [7:0] be, input string tag);
        run(line, off, io ? 5'b00100 : 5'b00010, be, 1, 3'b001, -1, tag);
        chk(rbuf[0] === (exp_mem[sidx(io, line, off)] & bmask(be)), tag, rbuf[0],
            exp_mem[sidx(io, line, off)] & bmask(be));
    endtask

    task automatic t_part_write(input bit io, input int line, input int off, input logic [7:0] be,
                                input logic [63:0] w, input string tag);
        wbuf[0] = w;
        run(line, off, io ? 5'b00101 : 5'b00011, be, 1, 3'b001, -1, tag);
        exp_mem[sidx(io, line, off)] = (exp_mem[sidx(io, line, off)] & ~bmask(be)) | (w & bmask(be));
    endtask

    task automatic t_bad_code(input logic [4:0] code);
        wbuf[0] = 64'hDEAD_BEEF_DEAD_BEEF;
        run(1, 6, code, 8'hFF, 1, 3'b011, -1, "R9 undefined code");
        chk(rbuf[0] == 64'd0, "R9 no data on fail", rbuf[0], 64'd0);
        t_part_read(0, 1, 6, 8'hFF, "R9 memory untouched");
    endtask

    task automatic t_busy_strobe;
        t_burst_read(1, 7, 3, "R11 strobe during burst");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(drdy_n == 1'b1, "R11 ignored strobe started nothing", 64'(drdy_n), 64'd1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_burst_write(1, 0, 16'h100);                           // R3 R4
        t_burst_read(1, 0, -1, "R4 burst read from line start");
        t_burst_read(1, 5, -1, "R5 burst read wrapping");
        t_burst_write(2, 3, 16'h200);                           // R5 wrapping write
        t_burst_read(2, 0, -1, "R5 wrapped write read back");
        t_part_write(0, 1, 2, 8'h0F, 64'h1122_3344_5566_7788, "R6 partial write low lanes");
        t_part_read(0, 1, 2, 8'hFF, "R6 merged quadword");
        t_part_read(0, 1, 4, 8'hA5, "R7 disabled lanes zero");
        t_part_write(1, 1, 2, 8'hFF, 64'h0F0F_F0F0_A5A5_5A5A, "R8 io write");
        t_part_read(0, 1, 2, 8'hFF, "R8 memory unchanged by io");
        t_part_read(1, 1, 2, 8'h3C, "R8 io read back");
        t_bad_code(5'b10110);
        t_bad_code(5'b11111);
        t_busy_strobe();
        t_part_write(0, 1, 1, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, "R12 zero-enable write");
        t_part_read(0, 1, 1, 8'hFF, "R12 quadword unchanged");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule